// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block holds received characters for one serial channel until the host collects them. The receiver deframer writes each finished byte with a strobe. It also sends a pulse at the middle of every stop bit it samples. The host takes the oldest byte with a read strobe. The byte at the head of the queue is always shown on `rd_data`, so a read strobe both returns that byte and removes it.

Two conditions can prompt the host to read. The first is a fill-level comparison against a selectable threshold. The second is a character timeout. The timeout fires when bytes have been waiting with no new stop bit and no host read for 4·P+12 bit times, where P is the programmed data width. Time is measured on a 16x baud tick, so one bit time is 16 ticks.

With queueing switched off, the block becomes a one-byte holding register. In that mode the threshold is fixed at one character and the timeout never fires.

The timeout is built as a three-state machine:
- `TM_IDLE` is the state while queueing is off, during a flush, or while the queue is empty. It moves to `TM_RUN` with a cleared counter on the cycle after data is present.
- `TM_RUN` counts baud ticks. It clears the counter on a stop-bit pulse or a host read. It moves to `TM_EXPIRED` when the tick count reaches the limit.
- `TM_EXPIRED` drives the timeout flag. It returns to `TM_RUN` with a cleared counter on a host read, a write or a stop-bit pulse.
- Every state falls back to `TM_IDLE` when the queue empties or queueing is disabled.

Top module: `uart_rx_fifo_tmo`

## Requirements
- R1: With `fifo_en`=1 the block stores up to 16 bytes and returns them in arrival order. `fill_cnt` gives the number held, and the head byte is visible on `rd_data`.
- R2: `data_rdy` is 1 exactly when `fill_cnt` is non-zero, and it is re-evaluated after every read. A read strobe while empty changes nothing.
- R3: `trig_hit` is 1 when `fill_cnt` is at or above the threshold chosen by `trig_sel`: 00=1, 01=4, 10=8, 11=14 characters.
- R4: A write while the queue holds its capacity is dropped, even if a read occurs in the same cycle, and `overrun` is set. `overrun` clears on the next accepted host read or on a flush.
- R5: `tmo_flag` rises once the data has waited (4·P+12)·16 asserted `baud_tick` cycles. P is the data width given by `word_len`: 00=5, 01=6, 10=7, 11=8 bits. Cycles with the tick low are not counted. For a write to an empty queue, the flag rises limit+1 clock edges after the write edge when the tick is held high.
- R6: A `stop_mid` pulse clears the timeout counter, so the flag rises exactly limit edges after that pulse with the tick held high.
- R7: A host read clears the timeout counter and the flag. A write or a stop-bit pulse also clears the flag.
- R8: `tmo_flag` is never 1 while `fill_cnt` is 0.
- R9: With `fifo_en`=0 the capacity is one byte, `trig_hit` uses a threshold of 1 whatever `trig_sel` is, and `tmo_flag` stays 0.
- R10: Any change of `fifo_en` empties the queue at the next clock edge. The flush takes priority over a write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-byte queue, 0 = single holding byte |
| trig_sel | input | 2 | Fill threshold select |
| word_len | input | 2 | Data width code for the timeout length |
| baud_tick | input | 1 | 16x baud enable, one cycle per tick |
| rx_wr | input | 1 | Write strobe from the deframer |
| rx_byte | input | 8 | Received byte |
| stop_mid | input | 1 | Pulse at the middle of a received stop bit |
| host_rd | input | 1 | Host read strobe, pops the head byte |
| rd_data | output | 8 | Head byte |
| fill_cnt | output | 5 | Bytes held |
| data_rdy | output | 1 | At least one byte held |
| trig_hit | output | 1 | Fill at or above threshold |
| tmo_flag | output | 1 | Character timeout pending |
| overrun | output | 1 | A write was dropped |

## Verification
The queue is filled through every threshold step and then pushed past its capacity. It is drained byte by byte against a scoreboard. This separates ordering errors from counting errors, and shows that dropping a write is different from overwriting an entry.

The timeout is measured to the exact edge in three settings:
- the tick held high, at two data widths;
- a stop-bit pulse in mid-count;
- the tick held low.

Together these separate errors in the length formula, the restart sources and the tick gating.

The single-byte mode and a flush caused by changing the mode check the capacity and threshold fallback. They also show that no timeout appears with an empty or disabled queue.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int unsigned BIT_TICKS = 16;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_RUN,
        TM_EXPIRED
    } tm_state_e;

    // threshold in characters for each select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    // timeout length in ticks: (4*P + 12) bit times, P = 5 + code
    function automatic int unsigned tmo_ticks(input logic [1:0] wl);
        int unsigned p;
        p = 5 + int'(unsigned'(wl));
        return (4 * p + 12) * BIT_TICKS;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         single,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    output logic [DW-1:0]                rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_wr, do_rd, drop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cap     = single ? CW'(1) : CW'(DEPTH);
        do_wr   = wr_en && (fill < cap);
        drop    = wr_en && !(fill < cap);
        do_rd   = rd_en && (fill != '0);
        rd_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            overrun <= 1'b0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= step(wr_ptr);
            if (do_rd) rd_ptr <= step(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
            if (drop)       overrun <= 1'b1;
            else if (do_rd) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_timer.sv
module rxf_timer
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       has_data,
    input  logic       tick,
    input  logic       stop_mid,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] wlen,
    output logic       expired
);
    localparam int CTW = $clog2(tmo_ticks(2'b11));

    tm_state_e      st_q, st_d;
    logic [CTW-1:0] cnt_q, cnt_d;
    logic [CTW-1:0] lim_m1;

    always_comb begin
        lim_m1 = CTW'(tmo_ticks(wlen) - 1);
        st_d   = st_q;
        cnt_d  = cnt_q;
        if (!enable || !has_data) begin
            st_d  = TM_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TM_IDLE: begin
                    st_d  = TM_RUN;
                    cnt_d = '0;
                end
                TM_RUN: begin
                    if (rd_en || stop_mid) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == lim_m1) begin
                            st_d  = TM_EXPIRED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CTW'(1);
                        end
                    end
                end
                TM_EXPIRED: begin
                    if (rd_en || wr_en || stop_mid) begin
                        st_d  = TM_RUN;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = TM_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TM_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        expired = (st_q == TM_EXPIRED);
    end
endmodule

// File: rtl/uart_rx_fifo_tmo.sv
module uart_rx_fifo_tmo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fifo_en,
    input  logic [1:0]                  trig_sel,
    input  logic [1:0]                  word_len,
    input  logic                        baud_tick,
    input  logic                        rx_wr,
    input  logic [DW-1:0]               rx_byte,
    input  logic                        stop_mid,
    input  logic                        host_rd,
    output logic [DW-1:0]               rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  fill_cnt,
    output logic                        data_rdy,
    output logic                        trig_hit,
    output logic                        tmo_flag,
    output logic                        overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          mode_q, flush;
    logic [CW-1:0] level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    always_comb begin
        flush    = (fifo_en != mode_q);
        level    = fifo_en ? CW'(rxf_pkg::trig_level(trig_sel)) : CW'(1);
        data_rdy = (fill_cnt != '0);
        trig_hit = (fill_cnt >= level);
    end

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .single  (!fifo_en),
        .wr_en   (rx_wr),
        .wr_data (rx_byte),
        .rd_en   (host_rd),
        .rd_data (rd_data),
        .fill    (fill_cnt),
        .overrun (overrun)
    );

    rxf_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en && !flush),
        .has_data (fill_cnt != '0),
        .tick     (baud_tick),
        .stop_mid (stop_mid),
        .rd_en    (host_rd),
        .wr_en    (rx_wr),
        .wlen     (word_len),
        .expired  (tmo_flag)
    );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          host_rd,
    input logic          rx_wr,
    input logic          stop_mid,
    input logic [CW-1:0] fill_cnt,
    input logic          tmo_flag
);
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    a_r8_no_tmo_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) |-> !tmo_flag);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && host_rd) |=> !tmo_flag);

    a_r7_char_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && rx_wr) |=> !tmo_flag);

    a_r6_stop_restart: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mid |=> !tmo_flag);

    a_r9_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (fill_cnt <= CW'(1)));

    a_r9_single_no_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !tmo_flag);
endmodule

bind uart_rx_fifo_tmo rxf_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .host_rd  (host_rd),
    .rx_wr    (rx_wr),
    .stop_mid (stop_mid),
    .fill_cnt (fill_cnt),
    .tmo_flag (tmo_flag)
);

// File: tb/uart_rx_fifo_tmo_bench.sv
module uart_rx_fifo_tmo_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [1:0] word_len = 2'b00;
    logic       baud_tick = 1'b0;
    logic       rx_wr = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       stop_mid = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fill_cnt;
    logic       data_rdy, trig_hit, tmo_flag, overrun;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];

    always #(PERIOD/2) clk = ~clk;

    uart_rx_fifo_tmo u_uart_rx_fifo_tmo (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .word_len(word_len), .baud_tick(baud_tick), .rx_wr(rx_wr),
        .rx_byte(rx_byte), .stop_mid(stop_mid), .host_rd(host_rd),
        .rd_data(rd_data), .fill_cnt(fill_cnt), .data_rdy(data_rdy),
        .trig_hit(trig_hit), .tmo_flag(tmo_flag), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compares the head byte whenever a read strobe is presented
    always @(negedge clk) begin
        if (rst_n && host_rd && exp_q.size() != 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R1 order", int'(rd_data), int'(e));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        int cap;
        cap = fifo_en ? 16 : 1;
        if (exp_q.size() < cap) exp_q.push_back(b);
        rx_wr = 1'b1; rx_byte = b; stop_mid = 1'b1;
        step();
        rx_wr = 1'b0; stop_mid = 1'b0;
    endtask

    task automatic pop();
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lim;
        wait_n(3);
        rst_n = 1'b1;
        step();
        chk("R2 reset fill", int'(fill_cnt), 0);
        chk("R2 reset rdy", int'(data_rdy), 0);
        chk("R8 reset tmo", int'(tmo_flag), 0);
        chk("R4 reset ovr", int'(overrun), 0);

        // R1 R3: fill through thresholds
        fifo_en = 1'b1;
        wait_n(2);
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
        chk("R3 below 4", int'(trig_hit), 0);
        push(8'h13);
        chk("R3 at 4", int'(trig_hit), 1);
        chk("R1 fill 4", int'(fill_cnt), 4);
        trig_sel = 2'b10; #1;
        chk("R3 below 8", int'(trig_hit), 0);
        for (int i = 0; i < 10; i++) push(8'h20 + 8'(i));
        trig_sel = 2'b11; #1;
        chk("R3 at 14", int'(trig_hit), 1);
        push(8'h40); push(8'h41);
        chk("R1 full", int'(fill_cnt), 16);
        chk("R4 no ovr yet", int'(overrun), 0);
        push(8'hEE);
        chk("R4 overrun set", int'(overrun), 1);
        chk("R4 full kept", int'(fill_cnt), 16);

        // R2: drain
        pop();
        chk("R4 ovr cleared", int'(overrun), 0);
        while (exp_q.size() != 0) begin
            pop();
            chk("R2 fill", int'(fill_cnt), exp_q.size());
            chk("R2 rdy", int'(data_rdy), (exp_q.size() != 0) ? 1 : 0);
        end
        pop();
        chk("R2 empty read", int'(fill_cnt), 0);

        // R5 R7 R8: timeout length, 7-bit word
        baud_tick = 1'b1; word_len = 2'b10;
        lim = (4 * 7 + 12) * 16;
        push(8'h55);
        wait_n(lim);
        chk("R5 before limit", int'(tmo_flag), 0);
        step();
        chk("R5 at limit", int'(tmo_flag), 1);
        pop();
        chk("R7 read clears", int'(tmo_flag), 0);
        wait_n(800);
        chk("R8 empty no tmo", int'(tmo_flag), 0);

        // R6: stop-bit restart, 5-bit word
        word_len = 2'b00;
        lim = (4 * 5 + 12) * 16;
        push(8'h61);
        wait_n(300);
        stop_mid = 1'b1; step(); stop_mid = 1'b0;
        wait_n(lim - 1);
        chk("R6 before limit", int'(tmo_flag), 0);
        step();
        chk("R6 at limit", int'(tmo_flag), 1);
        push(8'h62);
        chk("R7 char clears", int'(tmo_flag), 0);
        pop(); pop();

        // R5: no ticks, no timeout
        baud_tick = 1'b0;
        push(8'h70);
        wait_n(1000);
        chk("R5 tick gated", int'(tmo_flag), 0);
        pop();

        // R9: single holding byte
        fifo_en = 1'b0;
        step();
        exp_q.delete();
        push(8'hA1);
        push(8'hA2);
        chk("R9 cap one", int'(fill_cnt), 1);
        chk("R9 overrun", int'(overrun), 1);
        trig_sel = 2'b11; #1;
        chk("R9 fixed level", int'(trig_hit), 1);
        baud_tick = 1'b1;
        wait_n(800);
        chk("R9 no tmo", int'(tmo_flag), 0);
        pop();
        chk("R9 drained", int'(fill_cnt), 0);

        // R10: mode change flushes
        fifo_en = 1'b1;
        step();
        push(8'hB0); push(8'hB1); push(8'hB2);
        chk("R10 filled", int'(fill_cnt), 3);
        fifo_en = 1'b0;
        exp_q.delete();
        step();
        chk("R10 flushed", int'(fill_cnt), 0);
        chk("R10 rdy low", int'(data_rdy), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule